// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide parallel flash. It takes one of three requests: program a byte, erase one page, or erase the whole array. For each request it issues the unlock write sequence that the flash expects, one write per clock. It then reads status from the flash until the internal operation has finished. Completion is detected in one of two ways. In data-polling mode, bit 7 of a read from the target address must match its expected value. In toggle mode, bit 6 must stop changing between consecutive reads.

Bit 7 can settle before the lower bits do. For that reason the sequencer takes one more read after it sees completion, and it returns that byte with a one-cycle done pulse. A poll budget limits how long the sequencer waits: if completion is never seen within that budget, done is raised together with error. The request side is a valid/ready handshake that accepts only while the sequencer is idle. The flash side is a simple synchronous bus with single-cycle write and read strobes.

Top module: `flash_seq_top`

## Requirements
- R1: A program request (req_op=0) drives exactly four writes on consecutive cycles. The first write comes in the cycle after acceptance. The writes are (5555h,AAh), (2AAAh,55h), (5555h,A0h), (target address, target data).
- R2: A chip-erase request (req_op=2) drives six consecutive writes: (5555h,AAh), (2AAAh,55h), (5555h,80h), (5555h,AAh), (2AAAh,55h), (5555h,10h).
- R3: A page-erase request (req_op=1) drives the same first five writes as chip erase. The sixth write is (target address, 50h).
- R4: bus_re is high for one cycle per read and is never high in the same cycle as bus_we. Reads use the target address. bus_rdata is taken at the clock edge that follows the edge at which bus_re was high.
- R5: With poll_mode=0 (latched at acceptance), a read is complete when its bit 7 equals the expected value. The expected value is bit 7 of the programmed data for a program, and 1 for an erase.
- R6: With poll_mode=1, a read is complete when its bit 6 equals bit 6 of the previous read of the same operation. The first read after the writes cannot be complete.
- R7: After a complete read, one further read is issued. done then pulses for one cycle with error=0, and result_data holds that further read.
- R8: After POLL_LIMIT reads that are not complete, done pulses together with error=1 and no further read is issued.
- R9: req_ready is high only while idle. A request presented while req_ready is low is ignored, and a request with req_op=3 is dropped without any bus activity or done.
- R10: After reset, req_ready=1, bus_we=0, bus_re=0, done=0 and error=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 program, 1 page erase, 2 chip erase, 3 dropped |
| req_addr | input | ADDR_W | Target byte address (any address in the page for page erase) |
| req_data | input | 8 | Byte to program |
| poll_mode | input | 1 | 0 bit-7 data polling, 1 bit-6 toggle polling |
| bus_addr | output | ADDR_W | Flash bus address |
| bus_wdata | output | 8 | Flash bus write data |
| bus_we | output | 1 | Flash write strobe, one cycle per write |
| bus_re | output | 1 | Flash read strobe, one cycle per read |
| bus_rdata | input | 8 | Flash read data, valid one cycle after bus_re |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Timeout flag, valid with done |
| result_data | output | 8 | Byte from the confirming read |

## Verification
The bench builds the sequencer with ADDR_W=15, the narrowest width that still holds the command addresses, and with POLL_LIMIT=12. The small poll budget puts the timeout path within a dozen reads. With ADDR_W=15 the flash model has a 32 KB array, so erasing the whole array on every chip-erase run stays cheap. Each combination of operation and polling mode is swept across busy lengths of 0, 1, 2, 5 and 9 status reads. These lengths cover an immediate finish, both phases of the toggle bit at completion, and long waits that stay under the budget. Read counts are predicted arithmetically from each busy length and from the bit 6 value of the final data.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_PAGE = 2'd1,
        OP_CHIP = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WRITE = 3'd1,
        ST_READ  = 3'd2,
        ST_CAPT  = 3'd3,
        ST_FREAD = 3'd4,
        ST_FCAPT = 3'd5
    } st_e;

    localparam logic [14:0] UNLOCK_A = 15'h5555;
    localparam logic [14:0] UNLOCK_B = 15'h2AAA;
    localparam int          STEP_W   = 3;
endpackage

// File: rtl/fseq_cmd_table.sv
`timescale 1ns/1ps
module fseq_cmd_table
    import fseq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]            op,
    input  logic [STEP_W-1:0]     step,
    input  logic [ADDR_W-1:0]     tgt_addr,
    input  logic [7:0]            tgt_data,
    output logic [ADDR_W-1:0]     cmd_addr,
    output logic [7:0]            cmd_data,
    output logic                  cmd_last
);
    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNLOCK_A);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNLOCK_B);

    logic is_prog;
    assign is_prog = (op == OP_PROG);

    always_comb begin
        cmd_addr = ADR_A;
        cmd_data = 8'hAA;
        case (step)
            3'd0: begin cmd_addr = ADR_A; cmd_data = 8'hAA; end
            3'd1: begin cmd_addr = ADR_B; cmd_data = 8'h55; end
            3'd2: begin cmd_addr = ADR_A; cmd_data = is_prog ? 8'hA0 : 8'h80; end
            3'd3: begin
                cmd_addr = is_prog ? tgt_addr : ADR_A;
                cmd_data = is_prog ? tgt_data : 8'hAA;
            end
            3'd4: begin cmd_addr = ADR_B; cmd_data = 8'h55; end
            3'd5: begin
                cmd_addr = (op == OP_PAGE) ? tgt_addr : ADR_A;
                cmd_data = (op == OP_PAGE) ? 8'h50 : 8'h10;
            end
            default: begin cmd_addr = ADR_A; cmd_data = 8'hAA; end
        endcase
        cmd_last = is_prog ? (step == 3'd3) : (step == 3'd5);
    end
endmodule

// File: rtl/fseq_poll_judge.sv
`timescale 1ns/1ps
module fseq_poll_judge (
    input  logic mode,
    input  logic dq7,
    input  logic dq6,
    input  logic exp7,
    input  logic prev6,
    input  logic prev_ok,
    output logic complete
);
    always_comb begin
        if (mode) complete = prev_ok && (dq6 == prev6);
        else      complete = (dq7 == exp7);
    end
endmodule

// File: rtl/fseq_poll_timer.sv
`timescale 1ns/1ps
module fseq_poll_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expire = tick && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear || expire) cnt_d = '0;
        else if (tick)       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < CW'(LIMIT)); // R8
endmodule

// File: rtl/flash_seq_top.sv
`timescale 1ns/1ps
module flash_seq_top
    import fseq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              poll_mode,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [7:0]        bus_rdata,
    output logic              done,
    output logic              error,
    output logic [7:0]        result_data
);
    typedef struct packed {
        st_e               st;
        logic [1:0]        op;
        logic              mode;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [STEP_W-1:0] step;
        logic              prev6;
        logic              prev_ok;
        logic              done;
        logic              err;
        logic [7:0]        result;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_data;
    logic              cmd_last;
    logic              complete;
    logic              expire;
    logic              exp7;

    assign exp7 = (r_q.op == OP_PROG) ? r_q.data[7] : 1'b1;

    fseq_cmd_table #(.ADDR_W(ADDR_W)) u_cmd (
        .op       (r_q.op),
        .step     (r_q.step),
        .tgt_addr (r_q.addr),
        .tgt_data (r_q.data),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .cmd_last (cmd_last)
    );

    fseq_poll_judge u_judge (
        .mode     (r_q.mode),
        .dq7      (bus_rdata[7]),
        .dq6      (bus_rdata[6]),
        .exp7     (exp7),
        .prev6    (r_q.prev6),
        .prev_ok  (r_q.prev_ok),
        .complete (complete)
    );

    fseq_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (r_q.st == ST_IDLE),
        .tick   ((r_q.st == ST_CAPT) && !complete),
        .expire (expire)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid && (req_op != OP_NONE)) begin
                    r_d.st   = ST_WRITE;
                    r_d.op   = req_op;
                    r_d.mode = poll_mode;
                    r_d.addr = req_addr;
                    r_d.data = req_data;
                    r_d.step = '0;
                end
            end
            ST_WRITE: begin
                if (cmd_last) begin
                    r_d.st      = ST_READ;
                    r_d.prev_ok = 1'b0;
                end else begin
                    r_d.step = r_q.step + 1'b1;
                end
            end
            ST_READ: r_d.st = ST_CAPT;
            ST_CAPT: begin
                if (complete) begin
                    r_d.st = ST_FREAD;
                end else if (expire) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                end else begin
                    r_d.st      = ST_READ;
                    r_d.prev6   = bus_rdata[6];
                    r_d.prev_ok = 1'b1;
                end
            end
            ST_FREAD: r_d.st = ST_FCAPT;
            ST_FCAPT: begin
                r_d.st     = ST_IDLE;
                r_d.result = bus_rdata;
                r_d.done   = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign bus_we      = (r_q.st == ST_WRITE);
    assign bus_re      = (r_q.st == ST_READ) || (r_q.st == ST_FREAD);
    assign bus_addr    = bus_we ? cmd_addr : r_q.addr;
    assign bus_wdata   = bus_we ? cmd_data : 8'h00;
    assign done        = r_q.done;
    assign error       = r_q.err;
    assign result_data = r_q.result;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bus_we && bus_re)); // R4
    AST_START_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op != 2'd3) |=> (bus_we && bus_wdata == 8'hAA)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) error |-> done); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we || bus_re) |-> !req_ready); // R9
    AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> !bus_re && !bus_we); // R4
endmodule

// File: tb/sim_flash_seq_top.sv
`timescale 1ns/1ps
module sim_flash_seq_top;
    localparam int AW    = 15;
    localparam int LIMIT = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'h00;
    logic          poll_mode = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_we;
    logic          bus_re;
    logic [7:0]    bus_rdata = 8'h00;
    logic          done;
    logic          error;
    logic [7:0]    result_data;

    always #2.5 clk = ~clk;

    flash_seq_top #(.ADDR_W(AW), .POLL_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .poll_mode(poll_mode),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .done(done), .error(error), .result_data(result_data)
    );

    // behavioural flash responder
    logic [7:0]    fmem [0:(1<<AW)-1];
    logic [AW-1:0] wlog_a [0:15];
    logic [7:0]    wlog_d [0:15];
    int            nw, nr, ndone, busy, scnt, busy_len;
    logic          stuck = 1'b0, clr = 1'b0, st_prog = 1'b0, pd7 = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1<<AW); i++) fmem[i] = 8'hFF;
            nw = 0; nr = 0; ndone = 0; busy = 0; scnt = 0;
        end else begin
            if (clr) begin nw = 0; nr = 0; ndone = 0; end
            if (done) ndone = ndone + 1;
            if (bus_we) begin
                if (nw < 16) begin wlog_a[nw] = bus_addr; wlog_d[nw] = bus_wdata; end
                if (nw == 3 && wlog_d[2] == 8'hA0) begin
                    fmem[bus_addr] = fmem[bus_addr] & bus_wdata;
                    st_prog = 1'b1; pd7 = bus_wdata[7]; busy = busy_len; scnt = 0;
                end
                if (nw == 5 && bus_wdata == 8'h10) begin
                    for (int i = 0; i < (1<<AW); i++) fmem[i] = 8'hFF;
                    st_prog = 1'b0; busy = busy_len; scnt = 0;
                end
                if (nw == 5 && bus_wdata == 8'h50) begin
                    for (int i = 0; i < 4096; i++) fmem[{bus_addr[AW-1:12], 12'h000} + i] = 8'hFF;
                    st_prog = 1'b0; busy = busy_len; scnt = 0;
                end
                nw = nw + 1;
            end
            if (bus_re) begin
                nr = nr + 1;
                if (busy > 0 || stuck) begin
                    scnt = scnt + 1;
                    if (st_prog) bus_rdata <= {~pd7, scnt[0], 6'b010101};
                    else         bus_rdata <= {1'b0, scnt[0], 6'b101010};
                    if (!stuck) busy = busy - 1;
                end else begin
                    bus_rdata <= fmem[bus_addr];
                end
            end
        end
    end

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                          input logic mode, input int blen, input bit stall);
        logic [AW-1:0] ea [0:5];
        logic [7:0]    ed [0:5];
        int            nexp, rexp, w;
        logic [7:0]    expres;
        string         rq;
        rq = (op == 2'd0) ? "R1" : (op == 2'd1) ? "R3" : "R2";
        ea[0] = AW'(15'h5555); ed[0] = 8'hAA;
        ea[1] = AW'(15'h2AAA); ed[1] = 8'h55;
        ea[2] = AW'(15'h5555); ed[2] = (op == 2'd0) ? 8'hA0 : 8'h80;
        ea[3] = (op == 2'd0) ? a : AW'(15'h5555); ed[3] = (op == 2'd0) ? d : 8'hAA;
        ea[4] = AW'(15'h2AAA); ed[4] = 8'h55;
        ea[5] = (op == 2'd1) ? a : AW'(15'h5555); ed[5] = (op == 2'd1) ? 8'h50 : 8'h10;
        nexp = (op == 2'd0) ? 4 : 6;
        expres = (op == 2'd0) ? (fmem[a] & d) : 8'hFF;
        if (stall) rexp = LIMIT;
        else if (!mode) rexp = blen + 2;
        else if (blen == 0) rexp = 3;
        else rexp = ((blen & 1) == int'(expres[6])) ? blen + 2 : blen + 3;
        @(negedge clk); busy_len = blen; stuck = stall; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; poll_mode = mode;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 ready low while busy", int'(req_ready), 0);
        req_valid = 1'b1; req_op = 2'd0; req_addr = a ^ 15'h0100; req_data = 8'h00; poll_mode = ~mode;
        @(negedge clk); req_valid = 1'b0;
        w = 0;
        while (!done && w < 400) begin @(negedge clk); w++; end
        chk(done == 1'b1, "R7 done seen", int'(done), 1);
        chk(nw == nexp, {rq, " write count"}, nw, nexp);
        for (int i = 0; i < nexp; i++) begin
            chk(wlog_a[i] == ea[i] && wlog_d[i] == ed[i], {rq, " write step"},
                int'({wlog_a[i], wlog_d[i]}), int'({ea[i], ed[i]}));
        end
        if (stall) begin
            chk(error == 1'b1, "R8 timeout error", int'(error), 1);
            chk(nr == rexp, "R8 reads before timeout", nr, rexp);
        end else begin
            chk(error == 1'b0, "R7 no error", int'(error), 0);
            chk(nr == rexp, mode ? "R6 toggle read count" : "R5 data poll read count", nr, rexp);
            chk(result_data == expres, "R7 result data", int'(result_data), int'(expres));
        end
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
        repeat (6) @(negedge clk);
        chk(nw == nexp && ndone == 1, "R9 ignored request", nw * 16 + ndone, nexp * 16 + 1);
        stuck = 1'b0;
    endtask

    initial begin
        int lens [0:4];
        logic [7:0] dv;
        lens[0] = 0; lens[1] = 1; lens[2] = 2; lens[3] = 5; lens[4] = 9;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_we && !bus_re && !done && !error, "R10 reset state",
            int'({req_ready, bus_we, bus_re, done, error}), 5'b10000);
        for (int op = 0; op < 3; op++) begin
            for (int m = 0; m < 2; m++) begin
                for (int b = 0; b < 5; b++) begin
                    dv = 8'(8'h3C + 8'd67 * (op * 10 + m * 5 + b));
                    run_op(2'(op), AW'(15'h0400 * (op * 10 + m * 5 + b) + 15'h0013), dv, m[0], lens[b], 1'b0);
                end
            end
        end
        run_op(2'd0, AW'(15'h7123), 8'h5A, 1'b0, 0, 1'b1);
        run_op(2'd1, AW'(15'h3456), 8'h00, 1'b1, 0, 1'b1);
        // dropped opcode
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        req_valid = 1'b1; req_op = 2'd3; req_addr = AW'(15'h0042);
        @(negedge clk); req_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(nw == 0 && nr == 0 && ndone == 0, "R9 opcode 3 dropped", nw + nr + ndone, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule